// File: doc/BRIEF.md
# GPIO Input Debounce Filter

This block cleans up one general-purpose input pin before its level reaches pin status and edge or level interrupt detection. The raw pad level is first brought into the system clock domain through a two-flop synchronizer. A small state machine then decides whether a change of the synchronized level is passed on at once or must first prove itself stable for a programmable window. The window is measured in periods of a slow reference clock of about 32.768 kHz, which arrives as a one-cycle enable pulse (`ref_tick`) in the system clock domain.

The window length is a 4-bit count multiplied by one of four unit sizes picked by a two-bit selector. A two-bit mode field chooses what is filtered. Mode 0 disables filtering. Mode 1 qualifies only rising changes and so keeps short low-going glitches. Mode 2 qualifies only falling changes and so keeps short high-going glitches. Mode 3 qualifies changes in both directions. The state machine has two states. In STEADY the output equals the synchronized input, or a change is pending that will be accepted at once. In QUALIFY a change on a filtered edge is being timed.

The transitions are as follows. STEADY goes to QUALIFY on a filtered change when the window is nonzero. STEADY stays in STEADY with an immediate output update on an unfiltered change. QUALIFY goes back to STEADY with the output unchanged when the input reverts. QUALIFY goes to STEADY with the output updated when the window expires, or when the settings stop requiring a wait. QUALIFY stays in QUALIFY with its counter cleared when any setting changes.

Top module: `pin_deglitch`

## Requirements
- R1: While `rst_n` is low, `pin_filt` is 0, and it stays 0 after reset while the input stays low.
- R2: With `db_mode` = 0 (bypass), `pin_filt` follows `pin_raw` with a latency of exactly three clock edges: two synchronizer flops and the output register. Even a one-cycle pulse is passed.
- R3: `unit_sel` picks the unit of the window in `ref_tick` periods: 0 gives 2, 1 gives 8, 2 gives 512 and 3 gives 2048. The window W is `db_count` × unit.
- R4: A change on a filtered edge reaches `pin_filt` only when the synchronized level differs from `pin_filt` for W+1 consecutive cycles while `ref_tick` is high every cycle. A pulse of W cycles is dropped and a pulse of W+1 cycles is passed. `pin_filt` only ever moves to the synchronized level.
- R5: A reversal of the input before the window expires cancels the pending change. Two W-cycle pulses separated by a one-cycle gap are both dropped.
- R6: In mode 3, both rising and falling changes are qualified.
- R7: In mode 1, rising changes are qualified and falling changes pass at once.
- R8: In mode 2, falling changes are qualified and rising changes pass at once.
- R9: With `db_count` = 0, there is no delay in any mode. A one-cycle pulse passes.
- R10: The window counter advances only in cycles where `ref_tick` is 1. With `ref_tick` held at 0, a pending filtered change is never accepted.
- R11: Any change of `db_count`, `unit_sel` or `db_mode` restarts the window. `pin_filt` holds its value until a change is qualified under the new settings.
- R12: The largest count, 15, gives a window of 15 units. With unit 0, a 30-cycle pulse is dropped and a 31-cycle pulse is passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_raw | input | 1 | Unsynchronized pad level |
| ref_tick | input | 1 | One-cycle enable per reference-clock period |
| db_count | input | CNT_W | Window length in units |
| unit_sel | input | 2 | Unit size select (2, 8, 512 or 2048 ticks) |
| db_mode | input | 2 | 0 bypass, 1 qualify rising, 2 qualify falling, 3 qualify both |
| pin_filt | output | 1 | Filtered level for status and interrupt logic |

## Verification
The bound checker checks the following on every cycle:
- the reset value of the output;
- that the output only ever moves to the synchronized input;
- that in bypass and zero-count settings the output follows the synchronized level one edge later;
- that without a tick no filtered edge can reach the output in any filtering mode.

The exact window length can only be shown by the bench's scenarios. These scenarios include:
- pulses of W and W+1 cycles in all four unit ranges;
- pulses in each direction under each mode;
- the restart on reversal and on a settings change;
- the maximum count.

The monitor counts output edges per scenario and compares them against the scoreboard queue.

// File: rtl/pin_deglitch_pkg.sv
package pin_deglitch_pkg;

    typedef enum logic [1:0] {
        DG_BYPASS    = 2'd0,
        DG_RISE_ONLY = 2'd1,
        DG_FALL_ONLY = 2'd2,
        DG_BOTH      = 2'd3
    } dg_mode_e;

    typedef enum logic {
        ST_STEADY  = 1'b0,
        ST_QUALIFY = 1'b1
    } dg_state_e;

endpackage

// File: rtl/pin_deglitch_sync.sv
module pin_deglitch_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q[i] <= 1'b0;
                end else if (i == 0) begin
                    chain_q[i] <= d_in;
                end else begin
                    chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate

    assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/pin_deglitch_span.sv
module pin_deglitch_span #(
    parameter int CNT_W  = 4,
    parameter int SPAN_W = 15,
    parameter int UNIT_0 = 2,
    parameter int UNIT_1 = 8,
    parameter int UNIT_2 = 512,
    parameter int UNIT_3 = 2048
) (
    input  logic [CNT_W-1:0]  count,
    input  logic [1:0]        unit_sel,
    output logic [SPAN_W-1:0] span
);
    logic [SPAN_W-1:0] unit_val;

    always_comb begin
        unique case (unit_sel)
            2'd0:    unit_val = SPAN_W'(UNIT_0);
            2'd1:    unit_val = SPAN_W'(UNIT_1);
            2'd2:    unit_val = SPAN_W'(UNIT_2);
            default: unit_val = SPAN_W'(UNIT_3);
        endcase
    end

    assign span = SPAN_W'(SPAN_W'(count) * unit_val);
endmodule

// File: rtl/pin_deglitch_fsm.sv
module pin_deglitch_fsm
    import pin_deglitch_pkg::*;
#(
    parameter int SPAN_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lvl,
    input  logic              tick,
    input  logic [1:0]        mode,
    input  logic [SPAN_W-1:0] span,
    input  logic              cfg_chg,
    output logic              out
);
    dg_state_e         st_q, st_n;
    logic              out_q, out_n;
    logic [SPAN_W-1:0] cnt_q, cnt_n;
    logic              dir_filtered;
    logic              need_wait;
    logic [SPAN_W:0]   cnt_inc;

    // A rising change is pending when lvl is 1, a falling one when lvl is 0.
    always_comb begin
        if (lvl) begin
            dir_filtered = (mode == DG_BOTH) || (mode == DG_RISE_ONLY);
        end else begin
            dir_filtered = (mode == DG_BOTH) || (mode == DG_FALL_ONLY);
        end
        need_wait = dir_filtered && (span != '0);
        cnt_inc   = {1'b0, cnt_q} + 1'b1;
    end

    always_comb begin
        st_n  = st_q;
        out_n = out_q;
        cnt_n = cnt_q;
        unique case (st_q)
            ST_STEADY: begin
                if (lvl != out_q) begin
                    if (need_wait) begin
                        st_n  = ST_QUALIFY;
                        cnt_n = '0;
                    end else begin
                        out_n = lvl;
                    end
                end
            end
            ST_QUALIFY: begin
                if (lvl == out_q) begin
                    st_n = ST_STEADY;
                end else if (!need_wait) begin
                    out_n = lvl;
                    st_n  = ST_STEADY;
                end else if (cfg_chg) begin
                    cnt_n = '0;
                end else if (tick) begin
                    if (cnt_inc >= {1'b0, span}) begin
                        out_n = lvl;
                        st_n  = ST_STEADY;
                    end else begin
                        cnt_n = cnt_inc[SPAN_W-1:0];
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_STEADY;
        end else begin
            st_q <= st_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            out_q <= out_n;
            cnt_q <= cnt_n;
        end
    end

    assign out = out_q;
endmodule

// File: rtl/pin_deglitch.sv
module pin_deglitch #(
    parameter int CNT_W       = 4,
    parameter int SYNC_STAGES = 2,
    parameter int UNIT_0      = 2,
    parameter int UNIT_1      = 8,
    parameter int UNIT_2      = 512,
    parameter int UNIT_3      = 2048
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_raw,
    input  logic             ref_tick,
    input  logic [CNT_W-1:0] db_count,
    input  logic [1:0]       unit_sel,
    input  logic [1:0]       db_mode,
    output logic             pin_filt
);
    localparam int SPAN_W = $clog2(((1 << CNT_W) - 1) * UNIT_3 + 1);
    localparam int CFG_W  = CNT_W + 4;

    logic              lvl_s;
    logic [SPAN_W-1:0] span;
    logic [CFG_W-1:0]  cfg_now, cfg_q;
    logic              cfg_chg;

    pin_deglitch_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (pin_raw),
        .d_out (lvl_s)
    );

    pin_deglitch_span #(
        .CNT_W  (CNT_W),
        .SPAN_W (SPAN_W),
        .UNIT_0 (UNIT_0),
        .UNIT_1 (UNIT_1),
        .UNIT_2 (UNIT_2),
        .UNIT_3 (UNIT_3)
    ) u_span (
        .count    (db_count),
        .unit_sel (unit_sel),
        .span     (span)
    );

    assign cfg_now = {db_count, unit_sel, db_mode};
    assign cfg_chg = (cfg_now != cfg_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_now;
        end
    end

    pin_deglitch_fsm #(.SPAN_W(SPAN_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl     (lvl_s),
        .tick    (ref_tick),
        .mode    (db_mode),
        .span    (span),
        .cfg_chg (cfg_chg),
        .out     (pin_filt)
    );
endmodule

// File: rtl/pin_deglitch_chk.sv
module pin_deglitch_chk #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sync_lvl,
    input logic             ref_tick,
    input logic [CNT_W-1:0] db_count,
    input logic [1:0]       db_mode,
    input logic             pin_filt
);
    p_reset_low_r1: assert property (@(posedge clk)
        !rst_n |-> !pin_filt);

    p_bypass_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (db_mode == 2'd0) |=> (pin_filt == $past(sync_lvl)));

    p_moves_to_input_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_filt != $past(pin_filt)) |-> (pin_filt == $past(sync_lvl)));

    p_zero_count_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (db_count == '0) |=> (pin_filt == $past(sync_lvl)));

    p_both_needs_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (db_mode == 2'd3 && db_count != '0 && !ref_tick) |=> $stable(pin_filt));

    p_rise_needs_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (db_mode == 2'd1 && db_count != '0 && !ref_tick && !pin_filt) |=> !pin_filt);

    p_fall_needs_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (db_mode == 2'd2 && db_count != '0 && !ref_tick && pin_filt) |=> pin_filt);
endmodule

bind pin_deglitch pin_deglitch_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_lvl (lvl_s),
    .ref_tick (ref_tick),
    .db_count (db_count),
    .db_mode  (db_mode),
    .pin_filt (pin_filt)
);

// File: tb/pin_deglitch_tb.sv
module pin_deglitch_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_raw = 1'b0;
    logic       ref_tick = 1'b1;
    logic [3:0] db_count = 4'd0;
    logic [1:0] unit_sel = 2'd0;
    logic [1:0] db_mode = 2'd0;
    logic       pin_filt;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    typedef struct {
        int    edges;
        logic  lvl;
        string rq;
    } exp_item_t;

    exp_item_t exp_q[$];
    int        edge_cnt = 0;
    logic      last_lvl = 1'b0;

    always #2 clk = ~clk;

    pin_deglitch u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_raw  (pin_raw),
        .ref_tick (ref_tick),
        .db_count (db_count),
        .unit_sel (unit_sel),
        .db_mode  (db_mode),
        .pin_filt (pin_filt)
    );

    task automatic check(input bit ok, input string rq, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    // Monitor: counts output edges and settles each scoreboard item.
    always @(negedge clk) begin
        if (rst_n) begin
            if (pin_filt !== last_lvl) edge_cnt++;
            last_lvl = pin_filt;
        end
        if (exp_q.size() > 0) begin
            exp_item_t it;
            it = exp_q.pop_front();
            check(edge_cnt == it.edges, it.rq, "output edges", edge_cnt, it.edges);
            check(pin_filt === it.lvl, it.rq, "final level", int'(pin_filt), int'(it.lvl));
            edge_cnt = 0;
        end
    end

    function automatic int unit_of(input logic [1:0] sel);
        case (sel)
            2'd0:    return 2;
            2'd1:    return 8;
            2'd2:    return 512;
            default: return 2048;
        endcase
    endfunction

    task automatic push_exp(input int e, input logic lv, input string rq);
        #1;
        exp_q.push_back('{e, lv, rq});
        @(negedge clk);
    endtask

    task automatic set_cfg(input logic [1:0] m, input logic [1:0] u, input logic [3:0] c);
        @(negedge clk);
        db_mode  = m;
        unit_sel = u;
        db_count = c;
        repeat (4) @(negedge clk);
    endtask

    // Drive the inverse of the baseline for len cycles, then settle.
    task automatic pulse(input logic base, input int len, input int settle);
        @(negedge clk);
        pin_raw = ~base;
        repeat (len) @(negedge clk);
        pin_raw = base;
        repeat (settle) @(negedge clk);
    endtask

    task automatic set_level(input logic v, input int settle);
        @(negedge clk);
        pin_raw = v;
        repeat (settle) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int w;
        repeat (5) @(negedge clk);
        check(pin_filt === 1'b0, "R1", "output in reset", int'(pin_filt), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(pin_filt === 1'b0, "R1", "output after reset", int'(pin_filt), 0);

        // R2: bypass latency of three edges, one-cycle pulse passes
        set_cfg(2'd0, 2'd3, 4'd15);
        pin_raw = 1'b1;
        repeat (2) @(negedge clk);
        check(pin_filt === 1'b0, "R2", "bypass before third edge", int'(pin_filt), 0);
        @(negedge clk);
        check(pin_filt === 1'b1, "R2", "bypass at third edge", int'(pin_filt), 1);
        pin_raw = 1'b0;
        repeat (6) @(negedge clk);
        push_exp(2, 1'b0, "R2");
        pulse(1'b0, 1, 8);
        push_exp(2, 1'b0, "R2");

        // R3, R4, R6: every unit range in mode 3, pulses of W and W+1 cycles
        for (int u = 0; u < 4; u++) begin
            logic [3:0] c;
            c = (u == 3) ? 4'd2 : 4'd3;
            w = int'(c) * unit_of(2'(u));
            set_cfg(2'd3, 2'(u), c);
            pulse(1'b0, w, 2 * w + 10);
            push_exp(0, 1'b0, "R3 R4 R6");
            pulse(1'b0, w + 1, 2 * w + 10);
            push_exp(2, 1'b0, "R3 R4 R6");
        end

        // R5: reversal restarts the window
        set_cfg(2'd3, 2'd0, 4'd3);
        @(negedge clk);
        pin_raw = 1'b1;
        repeat (6) @(negedge clk);
        pin_raw = 1'b0;
        @(negedge clk);
        pin_raw = 1'b1;
        repeat (6) @(negedge clk);
        pin_raw = 1'b0;
        repeat (20) @(negedge clk);
        push_exp(0, 1'b0, "R5");

        // R7: qualify rising only
        set_cfg(2'd1, 2'd1, 4'd3);
        w = 24;
        pulse(1'b0, w, 2 * w + 10);
        push_exp(0, 1'b0, "R7 rising glitch dropped");
        set_level(1'b1, w + 10);
        push_exp(1, 1'b1, "R7 baseline high");
        pulse(1'b1, 1, 2 * w + 10);
        push_exp(2, 1'b1, "R7 falling glitch kept");

        // R8: qualify falling only
        set_cfg(2'd2, 2'd1, 4'd3);
        pulse(1'b1, w, 2 * w + 10);
        push_exp(0, 1'b1, "R8 falling glitch dropped");
        set_level(1'b0, w + 10);
        push_exp(1, 1'b0, "R8 baseline low");
        pulse(1'b0, 1, 2 * w + 10);
        push_exp(2, 1'b0, "R8 rising glitch kept");

        // R9: zero count, no delay
        set_cfg(2'd3, 2'd0, 4'd0);
        pulse(1'b0, 1, 10);
        push_exp(2, 1'b0, "R9");

        // R10: no tick, no progress
        set_cfg(2'd3, 2'd0, 4'd3);
        ref_tick = 1'b0;
        pulse(1'b0, 40, 10);
        push_exp(0, 1'b0, "R10");
        ref_tick = 1'b1;

        // R11: a settings change restarts the window (W 8 -> 10)
        set_cfg(2'd3, 2'd0, 4'd4);
        @(negedge clk);
        pin_raw = 1'b1;
        repeat (6) @(negedge clk);
        db_count = 4'd5;
        repeat (6) @(negedge clk);
        check(pin_filt === 1'b0, "R11", "held after restart", int'(pin_filt), 0);
        repeat (10) @(negedge clk);
        check(pin_filt === 1'b1, "R11", "accepted under new window", int'(pin_filt), 1);
        pin_raw = 1'b0;
        repeat (20) @(negedge clk);
        push_exp(2, 1'b0, "R11");

        // R12: maximum count, window 30
        set_cfg(2'd3, 2'd0, 4'd15);
        pulse(1'b0, 30, 70);
        push_exp(0, 1'b0, "R12");
        pulse(1'b0, 31, 70);
        push_exp(2, 1'b0, "R12");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule